// File: doc/BRIEF.md
# Dual-Output Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines and routes each one to one of two interrupt outputs. Software reaches it over a simple 32-bit register bus that has a write strobe, a read strobe, a byte address and a data word. Each request line is sampled into a raw register on every clock, and software can read that register. A per-source enable mask gates the raw requests. A per-source routing bit then sends each enabled request to output 0 or to output 1. Each output has its own masked status register and its own registered interrupt line.

Software never writes the enable mask directly. A write to the set port raises the mask bits that carry a one. A write to the clear port lowers the mask bits that carry a one. Zero bits leave the mask unchanged in both cases, so two agents can enable and disable different sources without a read-modify-write race. The top mask bit is a global gate. While it is low, both status registers and both interrupt outputs stay at zero. Source 31 shares this bit, so it is enabled exactly when the global gate is open. A typical service routine reads the output-0 status, handles each set bit, and writes any bit it cannot handle to the clear port to silence that source.

Top module: `intc_dual_out`

## Requirements
- R1: After reset, the enable mask and the routing register are all zeros, both interrupt outputs are low and the read data is zero.
- R2: A write to byte address 0x34 (set port) sets each mask bit whose data bit is 1 and leaves the other bits unchanged. A read at 0x34 or at 0x38 returns the current mask.
- R3: A write to byte address 0x38 (clear port) clears each mask bit whose data bit is 1 and leaves the other bits unchanged.
- R4: The routing register at byte address 0x20 is read/write. Routing bit i = 0 selects output 0 for source i, and 1 selects output 1.
- R5: A read at byte address 0x30 returns the request inputs as sampled one clock earlier. Writes to 0x30 change nothing.
- R6: A read at byte address 0x00 returns raw AND mask AND NOT routing while mask bit 31 is 1.
- R7: A read at byte address 0x04 returns raw AND mask AND routing while mask bit 31 is 1.
- R8: While mask bit 31 is 0, both status reads return zero and both outputs are low.
- R9: Each interrupt output is the OR of its status bits, registered, so it follows the status one clock later.
- R10: Reads at any other address return zero, and writes to any other address change no state.
- R11: Read data is registered. It appears on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqIn | input | 32 | Level request lines, one per source |
| irqOut0 | output | 1 | Interrupt output 0 |
| irqOut1 | output | 1 | Interrupt output 1 |

## Verification
If the mask holds a wrong bit after a set or clear write, the status reads show it at once. An interrupt output also rises or stays low wrongly two clocks after the request changes. If the routing bit is wrong, the request appears in the other status register and on the other output line. If the global gate is wrong, both outputs are affected together. The bench writes pseudo-random routing, set and clear patterns and drives pseudo-random request patterns. It computes the expected mask and statuses arithmetically, so a fault in any single bit position shows in the next read of the status, routing, raw or mask registers.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT0,
    RD_STAT1,
    RD_ROUTE,
    RD_RAW,
    RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic   setMask;
    logic   clrMask;
    logic   wrRoute;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFF_ST0  = 'h00,
  parameter int OFF_ST1  = 'h04,
  parameter int OFF_RTE  = 'h20,
  parameter int OFF_RAW  = 'h30,
  parameter int OFF_SET  = 'h34,
  parameter int OFF_CLR  = 'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] A_ST0 = ADDR_W'(OFF_ST0);
  localparam logic [ADDR_W-1:0] A_ST1 = ADDR_W'(OFF_ST1);
  localparam logic [ADDR_W-1:0] A_RTE = ADDR_W'(OFF_RTE);
  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = RD_NONE;
    strobes.rdStrobe = rdEn;
    if (wrEn) begin
      // R10: no strobe for unmapped or read-only addresses (R5)
      strobes.setMask = (addr == A_SET);
      strobes.clrMask = (addr == A_CLR);
      strobes.wrRoute = (addr == A_RTE);
    end
    if (rdEn) begin
      unique case (addr)
        A_ST0:        strobes.rdSel = RD_STAT0;
        A_ST1:        strobes.rdSel = RD_STAT1;
        A_RTE:        strobes.rdSel = RD_ROUTE;
        A_RAW:        strobes.rdSel = RD_RAW;
        A_SET, A_CLR: strobes.rdSel = RD_MASK;
        default:      strobes.rdSel = RD_NONE;
      endcase
    end
  end

  // R10: at most one state-changing strobe per cycle
  a_r10_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.setMask, strobes.clrMask, strobes.wrRoute}));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [N_SRC-1:0] wrData,
  input  logic [N_SRC-1:0] irqIn,
  output logic [N_SRC-1:0] rdData,
  output logic             irqOut0,
  output logic             irqOut1
);
  localparam int GATE_BIT = N_SRC - 1;

  logic [N_SRC-1:0] rawQ, maskQ, routeQ;
  logic [N_SRC-1:0] stat0, stat1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ   <= '0;
      maskQ  <= '0;
      routeQ <= '0;
    end else begin
      rawQ <= irqIn;
      if (strobes.setMask)      maskQ <= maskQ | wrData;
      else if (strobes.clrMask) maskQ <= maskQ & ~wrData;
      if (strobes.wrRoute)      routeQ <= wrData;
    end
  end

  always_comb begin
    stat0 = '0;
    stat1 = '0;
    if (maskQ[GATE_BIT]) begin
      stat0 = rawQ & maskQ & ~routeQ;
      stat1 = rawQ & maskQ & routeQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut0 <= 1'b0;
      irqOut1 <= 1'b0;
      rdData  <= '0;
    end else begin
      irqOut0 <= |stat0;
      irqOut1 <= |stat1;
      if (strobes.rdStrobe) begin
        unique case (strobes.rdSel)
          RD_STAT0: rdData <= stat0;
          RD_STAT1: rdData <= stat1;
          RD_ROUTE: rdData <= routeQ;
          RD_RAW:   rdData <= rawQ;
          RD_MASK:  rdData <= maskQ;
          default:  rdData <= '0;
        endcase
      end
    end
  end

  // R2: a set write never drops a bit and raises every written one
  a_r2_set_grows: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMask |=> ((maskQ & $past(maskQ)) == $past(maskQ))
                        && ((maskQ & $past(wrData)) == $past(wrData)));
  // R3: a clear write never raises a bit and lowers every written one
  a_r3_clr_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrMask |=> ((maskQ & ~$past(maskQ)) == '0)
                        && ((maskQ & $past(wrData)) == '0));
  // R4: routing changes only on its own write
  a_r4_route_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrRoute |=> $stable(routeQ));
  // R8: closed gate keeps both outputs low
  a_r8_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    !maskQ[GATE_BIT] |=> !irqOut0 && !irqOut1);
  // R6 R7: a source never reaches both outputs
  a_r7_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (stat0 & stat1) == '0);
endmodule

// File: rtl/intc_dual_out.sv
module intc_dual_out
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wrData,
  output logic [N_SRC-1:0]  rdData,
  input  logic [N_SRC-1:0]  irqIn,
  output logic              irqOut0,
  output logic              irqOut1
);
  ctlStrobes_t strobes;

  intc_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .strobes(strobes)
  );

  intc_datapath #(.N_SRC(N_SRC)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .irqIn(irqIn), .rdData(rdData), .irqOut0(irqOut0), .irqOut1(irqOut1)
  );
endmodule

// File: tb/intc_dual_out_test.sv
`timescale 1ns/1ps
module intc_dual_out_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0, rdEn = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0, rdData, irqIn = '0;
  logic        irqOut0, irqOut1;
  int checks = 0, failures = 0;
  logic [31:0] mdlMask = '0, mdlRoute = '0, lcg = 32'h1234_5678;
  logic        done = 0;

  always #10 clk = ~clk;

  intc_dual_out uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqIn(irqIn),
    .irqOut0(irqOut0), .irqOut1(irqOut1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1; addr = a;
    @(posedge clk); #1 d = rdData;
    @(negedge clk); rdEn = 0;
  endtask

  function automatic logic [31:0] nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  function automatic logic [31:0] expS(input bit one);
    if (!mdlMask[31]) return '0;
    return irqIn & mdlMask & (one ? mdlRoute : ~mdlRoute);
  endfunction

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(8'h30, v); chk({"R5 raw ", tag}, v, irqIn);
    rd(8'h00, v); chk({"R6 stat0 ", tag}, v, expS(0));
    rd(8'h04, v); chk({"R7 stat1 ", tag}, v, expS(1));
    rd(8'h34, v); chk({"R2 mask@set ", tag}, v, mdlMask);
    rd(8'h38, v); chk({"R3 mask@clr ", tag}, v, mdlMask);
    rd(8'h20, v); chk({"R4 route ", tag}, v, mdlRoute);
    chk({"R9 out0 ", tag}, 32'(irqOut0), 32'(|expS(0)));
    chk({"R9 out1 ", tag}, 32'(irqOut1), 32'(|expS(1)));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    chk("R1 out0", 32'(irqOut0), 0);
    chk("R1 out1", 32'(irqOut1), 0);
    chk("R1 rdData", rdData, 0);
    rd(8'h34, v); chk("R1 mask", v, 0);
    rd(8'h20, v); chk("R1 route", v, 0);

    // R8: gate closed, requests present, all sources enabled except gate
    irqIn = 32'hFFFF_FFFF;
    wr(8'h34, 32'h7FFF_FFFF); mdlMask = 32'h7FFF_FFFF;
    repeat (2) @(negedge clk);
    checkAll("R8 gate closed");

    // R11: read data holds after the strobe drops
    rd(8'h30, v);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdData, 32'hFFFF_FFFF);

    // R5: raw write ignored; R10: unmapped writes and reads
    wr(8'h30, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 unmapped read", v, 0);
    rd(8'h35, v); chk("R10 unaligned read", v, 0);
    checkAll("R5 R10 after ignored writes");

    // R5: one-cycle sampling latency
    @(negedge clk); irqIn = 32'h0000_00A5;
    @(posedge clk); #1;
    @(negedge clk); rdEn = 1; addr = 8'h30;
    @(posedge clk); #1 chk("R5 latency", rdData, 32'h0000_00A5);
    @(negedge clk); rdEn = 0;

    // walking single source with gate open, both routings
    wr(8'h34, 32'h8000_0000); mdlMask[31] = 1;
    for (int i = 0; i < 31; i++) begin
      irqIn = 32'(1) << i;
      mdlRoute = (i % 2) ? (32'(1) << i) : 32'h0;
      wr(8'h20, mdlRoute);
      repeat (2) @(negedge clk);
      chk("R9 walk out0", 32'(irqOut0), 32'((i % 2) == 0));
      chk("R9 walk out1", 32'(irqOut1), 32'((i % 2) == 1));
      rd((i % 2) ? 8'h04 : 8'h00, v);
      chk("R6 R7 walk status", v, 32'(1) << i);
    end

    // pseudo-random sweep of routing, set, clear and requests
    for (int k = 0; k < 60; k++) begin
      a = nxt(); b = nxt();
      wr(8'h20, a); mdlRoute = a;
      wr(8'h34, b); mdlMask = mdlMask | b;
      a = nxt();
      if (k % 3 == 0) a[31] = 1'b0;
      wr(8'h38, a); mdlMask = mdlMask & ~a;
      irqIn = nxt();
      repeat (2) @(negedge clk);
      checkAll("R2 R3 R6 R7 sweep");
    end

    // R3: closing the gate through the clear port
    wr(8'h34, 32'hFFFF_FFFF); mdlMask = 32'hFFFF_FFFF;
    wr(8'h38, 32'h8000_0000); mdlMask[31] = 0;
    repeat (2) @(negedge clk);
    checkAll("R3 R8 gate cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule